// File: doc/BRIEF.md
# One-Time-Programmable Memory Burn Sequencer

This block programs a byte-wide one-time-programmable memory of 2^ADDR_W locations (64K x 8 by default). Core-supply and programming-voltage switches are driven as plain digital enables. Each write is a timed chip-enable low pulse. The block also drives the address bus, a data bus with a tristate enable, and the output enable, and it reads the memory's data bus back during checks. All intervals are clock-cycle counts derived from the `CLK_KHZ` parameter, with one microsecond equal to `CLK_KHZ/1000` cycles.

A run starts from idle on `start` and has three phases:

1. **Blind pass.** Every address gets exactly one pulse.
2. **Verify pass.** Every address is read back. A location that differs gets one more pulse and is read again after each pulse. This repeats up to ten extra pulses.
3. **Final read-back.** Both supplies are switched off and every location is read once more.

Bytes come from an external source, one fetch per address visit, through a request/valid pair. The result (`done`, `pass`, `fail`, `fail_addr`) stays unchanged until the next start.

Top module: `otp_burn_seq`

## Requirements
- R1: After reset the block is idle: busy, done, pass and fail are 0; both supply enables are off; mem_ce_n and mem_oe_n are 1; mem_dout_oe is 0; src_req is 0.
- R2: start is accepted only while busy is 0. A start pulse during a run has no effect on the pulses applied or on the result.
- R3: vcc_hi_en rises first. vpp_en rises at least 2 µs later. vpp_en is never 1 while vcc_hi_en is 0. Every write pulse occurs with both enables at 1.
- R4: A write pulse is mem_ce_n low with mem_dout_oe high. It lasts exactly 100 µs.
- R5: mem_addr and mem_dout are stable for at least 2 µs before a write pulse begins. mem_dout stays driven and unchanged for at least 2 µs after the pulse ends.
- R6: In the blind pass, addresses 0 to 2^ADDR_W-1 each receive one pulse, in ascending order. No read cycle occurs before the last of these pulses.
- R7: In the verify pass, a location whose read-back equals its byte gets no further pulse. A differing location gets single pulses, each followed by a read. The pass then moves to the next address.
- R8: The extra-pulse count restarts at zero for each address and never exceeds 10. If a location still differs after its tenth extra pulse, the run ends with fail=1, fail_addr set to that address, and no further pulse.
- R9: A read cycle is mem_ce_n and mem_oe_n both low. mem_dout_oe is 0 during the read and in the cycle before it. mem_din is sampled 1 µs plus one cycle after mem_ce_n falls.
- R10: At the end of the verify pass, or on a verify failure, vpp_en falls. vcc_hi_en falls at least 2 µs later, never earlier.
- R11: The final read-back runs with both enables off and reads every address in order. The first mismatch ends the run with fail=1 and fail_addr set to that address. Otherwise pass=1. done=1 implies exactly one of pass or fail.
- R12: done, pass, fail and fail_addr hold their values until the next accepted start, which clears them.
- R13: src_req stays high with src_addr equal to the current address until src_valid is seen. src_data is taken in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch a run when idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, result valid |
| pass | output | 1 | All bytes programmed and confirmed |
| fail | output | 1 | Run ended with a bad byte |
| fail_addr | output | ADDR_W | Address of the bad byte |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dout | output | 8 | Byte driven to the memory |
| mem_dout_oe | output | 1 | Tristate enable for mem_dout |
| mem_din | input | 8 | Byte read from the memory |
| mem_ce_n | output | 1 | Active-low chip enable / write pulse |
| mem_oe_n | output | 1 | Active-low output enable for reads |
| vcc_hi_en | output | 1 | Switch raised core supply on |
| vpp_en | output | 1 | Switch programming voltage on |
| src_req | output | 1 | Request for the byte at src_addr |
| src_addr | output | ADDR_W | Address of the requested byte |
| src_valid | input | 1 | src_data is valid |
| src_data | input | 8 | Requested byte |

## Verification
Some faults appear as a wrong pulse count at some address, seen as soon as that address is revisited. These include a miscounted retry counter, a lost reset of that counter between addresses, and a wrong limit. A wrong phase register shows up differently: as a read before the blind pass has finished, or as reads with the supplies still on during the final pass. A timer loaded with the wrong duration shows up at the very first pulse, as a measured width or setup interval that is off by cycles. Supply faults show up at the first supply edge of a run, as vpp_en rising too early or falling after the core supply.

// File: rtl/otp_seq_pkg.sv
// Shared types for the one-time-programmable memory burn sequencer.
// Assumes: one controller per memory; all widths set by the top's parameters.
package otp_seq_pkg;

    // Sequencer states; values carry no external meaning.
    typedef enum logic [3:0] {
        S_IDLE,
        S_VCC_ON,
        S_VPP_ON,
        S_FETCH,
        S_PGM_SU,
        S_PGM_PW,
        S_PGM_HD,
        S_RD_GUARD,
        S_RD_CE,
        S_RD_END,
        S_VPP_OFF,
        S_VCC_OFF
    } seq_state_t;

    // Which of the three passes is running.
    typedef enum logic [1:0] {
        PH_BLIND,
        PH_VERIFY,
        PH_FINAL
    } seq_phase_t;

    // Extra pulses allowed per byte in the verify pass.
    localparam int EXTRA_PULSE_MAX = 10;

endpackage

// File: rtl/seq_timer.sv
// Down-counting interval timer.
// A load at a state change sets the count. expired is high while the count is zero,
// so a loaded value V gives a state lasting V+1 cycles.
// Assumes: the owner reloads on every entry into a timed state.
module seq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // Load on request, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/retry_ctr.sv
// Per-address extra-pulse counter.
// Cleared whenever a new address is taken. at_limit reports that LIMIT extra pulses have been applied.
// Assumes: the owner never increments while at_limit is high.
module retry_ctr #(
    parameter int LIMIT = 10,
    localparam int RW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    logic [RW-1:0] cnt_q;

    // Clear has priority over increment.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt_q <= '0;
        else if (inc)
            cnt_q <= cnt_q + 1'b1;
    end

    assign at_limit = (cnt_q == RW'(LIMIT));

    // R8: the count never passes its limit
    assert_retry_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= RW'(LIMIT));

    // R8: the sequencer never asks for an eleventh extra pulse
    assert_no_inc_at_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |-> !at_limit);
endmodule

// File: rtl/otp_burn_seq.sv
// Burn sequencer for a byte-wide one-time-programmable memory.
// A run has three passes: blind (one pulse per address), verify with bounded retries,
// and an unpowered final read-back.
// Supply enables, bus controls and the byte source handshake are all driven here.
// Assumes: CLK_KHZ is a multiple of 1000; the byte source answers every request eventually.
module otp_burn_seq
    import otp_seq_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int CLK_KHZ = 50000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_dout,
    output logic              mem_dout_oe,
    input  logic [7:0]        mem_din,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              vcc_hi_en,
    output logic              vpp_en,
    output logic              src_req,
    output logic [ADDR_W-1:0] src_addr,
    input  logic              src_valid,
    input  logic [7:0]        src_data
);
    localparam int US    = (CLK_KHZ >= 1000) ? CLK_KHZ / 1000 : 1;
    localparam int T_PW  = 100 * US;
    localparam int T_SU  = 2 * US;
    localparam int T_HD  = 2 * US;
    localparam int T_VCS = 2 * US;
    localparam int T_RD  = US + 1;
    localparam int T_REC = US;
    localparam int TW    = $clog2(T_PW + 1);
    localparam int SW    = $clog2(T_SU + 1);
    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

    seq_state_t        state_q, state_d;
    seq_phase_t        phase_q;
    logic [ADDR_W-1:0] addr_q, fail_addr_q;
    logic [7:0]        byte_q;
    logic              match_q, vcc_q, vpp_q, fail_pend_q;
    logic              done_q, pass_q, fail_q;
    logic              tmr_done, tmr_load, at_limit;
    logic [TW-1:0]     tmr_val;
    logic              go, next_addr, to_verify, to_final, capture, latch_byte;
    logic              retry_inc, vpp_set, vpp_clr, vcc_clr, fail_mark, end_pass, end_fail;
    logic              is_last;

    assign is_last = (addr_q == LAST_ADDR);

    seq_timer #(.CNT_W(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_done)
    );

    retry_ctr #(.LIMIT(EXTRA_PULSE_MAX)) u_retry (
        .clk(clk), .rst_n(rst_n), .clr(go | next_addr | to_verify | to_final),
        .inc(retry_inc), .at_limit(at_limit)
    );

    // Next-state decision and the one-cycle strobes that update the datapath.
    always_comb begin
        state_d = state_q;
        {go, next_addr, to_verify, to_final, capture, latch_byte} = '0;
        {retry_inc, vpp_set, vpp_clr, vcc_clr, fail_mark, end_pass, end_fail} = '0;
        case (state_q)
            S_IDLE:     if (start) begin go = 1'b1; state_d = S_VCC_ON; end
            S_VCC_ON:   if (tmr_done) begin vpp_set = 1'b1; state_d = S_VPP_ON; end
            S_VPP_ON:   if (tmr_done) state_d = S_FETCH;
            S_FETCH:    if (src_valid) begin
                            latch_byte = 1'b1;
                            state_d = (phase_q == PH_BLIND) ? S_PGM_SU : S_RD_GUARD;
                        end
            S_PGM_SU:   if (tmr_done) state_d = S_PGM_PW;
            S_PGM_PW:   if (tmr_done) state_d = S_PGM_HD;
            S_PGM_HD:   if (tmr_done) begin
                            if (phase_q != PH_BLIND) state_d = S_RD_GUARD;
                            else begin
                                state_d = S_FETCH;
                                if (is_last) to_verify = 1'b1;
                                else         next_addr = 1'b1;
                            end
                        end
            S_RD_GUARD: if (tmr_done) state_d = S_RD_CE;
            S_RD_CE:    if (tmr_done) begin capture = 1'b1; state_d = S_RD_END; end
            S_RD_END:   if (tmr_done) begin
                            if (phase_q == PH_FINAL) begin
                                if (!match_q) begin
                                    fail_mark = 1'b1; end_fail = 1'b1; state_d = S_IDLE;
                                end else if (is_last) begin
                                    end_pass = 1'b1; state_d = S_IDLE;
                                end else begin
                                    next_addr = 1'b1; state_d = S_FETCH;
                                end
                            end else if (match_q) begin
                                if (is_last) begin vpp_clr = 1'b1; state_d = S_VPP_OFF; end
                                else begin next_addr = 1'b1; state_d = S_FETCH; end
                            end else if (at_limit) begin
                                fail_mark = 1'b1; vpp_clr = 1'b1; state_d = S_VPP_OFF;
                            end else begin
                                retry_inc = 1'b1; state_d = S_PGM_SU;
                            end
                        end
            S_VPP_OFF:  if (tmr_done) begin vcc_clr = 1'b1; state_d = S_VCC_OFF; end
            S_VCC_OFF:  if (tmr_done) begin
                            if (fail_pend_q) begin end_fail = 1'b1; state_d = S_IDLE; end
                            else begin to_final = 1'b1; state_d = S_FETCH; end
                        end
            default:    state_d = S_IDLE;
        endcase
    end

    // Reload the timer on every state change with the duration of the entered state.
    always_comb begin
        tmr_load = (state_d != state_q);
        case (state_d)
            S_VCC_ON, S_VCC_OFF:           tmr_val = TW'(T_VCS - 1);
            S_VPP_ON, S_PGM_SU, S_VPP_OFF: tmr_val = TW'(T_SU - 1);
            S_PGM_PW:                      tmr_val = TW'(T_PW - 1);
            S_PGM_HD:                      tmr_val = TW'(T_HD - 1);
            S_RD_CE:                       tmr_val = TW'(T_RD - 1);
            S_RD_END:                      tmr_val = TW'(T_REC - 1);
            default:                       tmr_val = '0;
        endcase
    end

    // State, phase, address, byte and supply registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            phase_q <= PH_BLIND;
            addr_q  <= '0;
            byte_q  <= '0;
            match_q <= 1'b0;
            vcc_q   <= 1'b0;
            vpp_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (go)         begin addr_q <= '0; phase_q <= PH_BLIND; vcc_q <= 1'b1; end
            if (to_verify)  begin addr_q <= '0; phase_q <= PH_VERIFY; end
            if (to_final)   begin addr_q <= '0; phase_q <= PH_FINAL; end
            if (next_addr)  addr_q <= addr_q + 1'b1;
            if (latch_byte) byte_q <= src_data;
            if (capture)    match_q <= (mem_din == byte_q);
            if (vpp_set)    vpp_q <= 1'b1;
            if (vpp_clr)    vpp_q <= 1'b0;
            if (vcc_clr)    vcc_q <= 1'b0;
        end
    end

    // Result registers: cleared by an accepted start, set once at the end of a run.
    always_ff @(posedge clk) begin
        if (!rst_n || go) begin
            done_q      <= 1'b0;
            pass_q      <= 1'b0;
            fail_q      <= 1'b0;
            fail_pend_q <= 1'b0;
            fail_addr_q <= '0;
        end else begin
            if (fail_mark) begin fail_addr_q <= addr_q; fail_pend_q <= 1'b1; end
            if (end_pass)  begin done_q <= 1'b1; pass_q <= 1'b1; end
            if (end_fail)  begin done_q <= 1'b1; fail_q <= 1'b1; end
        end
    end

    // Moore decode of the memory-side controls.
    always_comb begin
        mem_ce_n    = !(state_q == S_PGM_PW || state_q == S_RD_CE);
        mem_oe_n    = !(state_q == S_RD_GUARD || state_q == S_RD_CE);
        mem_dout_oe = (state_q == S_PGM_SU || state_q == S_PGM_PW || state_q == S_PGM_HD);
        src_req     = (state_q == S_FETCH);
    end

    assign busy      = (state_q != S_IDLE);
    assign done      = done_q;
    assign pass      = pass_q;
    assign fail      = fail_q;
    assign fail_addr = fail_addr_q;
    assign mem_addr  = addr_q;
    assign src_addr  = addr_q;
    assign mem_dout  = byte_q;
    assign vcc_hi_en = vcc_q;
    assign vpp_en    = vpp_q;

    // Checker counters: cycles of chip-enable low, and cycles address and data have held.
    logic [TW-1:0]     ce_low_q;
    logic [SW-1:0]     stab_q;
    logic [ADDR_W-1:0] seen_addr_q;
    logic [7:0]        seen_dout_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_low_q    <= '0;
            stab_q      <= '0;
            seen_addr_q <= '0;
            seen_dout_q <= '0;
        end else begin
            ce_low_q    <= mem_ce_n ? '0 : ce_low_q + 1'b1;
            seen_addr_q <= mem_addr;
            seen_dout_q <= mem_dout;
            if (mem_addr != seen_addr_q || mem_dout != seen_dout_q) stab_q <= SW'(1);
            else if (stab_q < SW'(T_SU))                            stab_q <= stab_q + 1'b1;
        end
    end

    // R3: programming voltage only with the raised core supply
    assert_vpp_needs_vcc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        vpp_en |-> vcc_hi_en);

    // R3: every write pulse starts with both supplies on
    assert_pulse_powered_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_ce_n) && mem_dout_oe) |-> (vpp_en && vcc_hi_en));

    // R4: a write pulse is exactly T_PW cycles long
    assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_ce_n) && mem_dout_oe) |-> (ce_low_q == TW'(T_PW)));

    // R5: address and data settled before the pulse
    assert_pulse_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_ce_n) && mem_dout_oe) |-> (stab_q == SW'(T_SU)));

    // R9: no data drive during a read or in the cycle before it
    assert_read_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !mem_oe_n) |-> (!mem_dout_oe && $past(!mem_dout_oe)));

    // R10: core supply never drops while programming voltage is on
    assert_supply_down_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vcc_hi_en) |-> (!vpp_en && $past(!vpp_en)));

    // R11: a finished run reports exactly one verdict
    assert_one_verdict_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pass ^ fail));

    // R12: results hold until a start
    assert_result_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(pass) && $stable(fail) && $stable(fail_addr)));

    // R13: a byte request holds until answered
    assert_src_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (src_req && !src_valid) |=> (src_req && $stable(src_addr)));
endmodule

// File: tb/otp_burn_seq_bench.sv
// Bench: a device model that programs a byte after a per-address number of pulses,
// a byte source, and a negedge monitor measuring timing.
// Results are compared with values computed from the requirements.
module otp_burn_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 3;
    localparam int N    = 1 << AW;
    localparam int TPW  = 100;
    localparam int TSU  = 2;
    localparam int THD  = 2;
    localparam int TVCS = 2;
    localparam int RUN_LIMIT = 40000;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic busy, done, pass, fail, mem_dout_oe, mem_ce_n, mem_oe_n, vcc_hi_en, vpp_en;
    logic src_req, src_valid;
    logic [AW-1:0] fail_addr, mem_addr, src_addr;
    logic [7:0] mem_dout, mem_din, src_data;

    otp_burn_seq #(.ADDR_W(AW), .CLK_KHZ(1000)) u_otp_burn_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .pass(pass),
        .fail(fail), .fail_addr(fail_addr), .mem_addr(mem_addr), .mem_dout(mem_dout),
        .mem_dout_oe(mem_dout_oe), .mem_din(mem_din), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .vcc_hi_en(vcc_hi_en), .vpp_en(vpp_en), .src_req(src_req),
        .src_addr(src_addr), .src_valid(src_valid), .src_data(src_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Stimulus tables written only by the initial block.
    logic [7:0] pat [N];
    int         need [N];
    int         corrupt_at = -1;
    logic       mdl_clear = 1'b0;

    // Byte source: answers one cycle after a request.
    always @(posedge clk) begin
        if (!rst_n) src_valid <= 1'b0;
        else begin
            src_valid <= src_req && !src_valid;
            src_data  <= pat[src_addr];
        end
    end

    // Device model and monitor state.
    logic [7:0] devmem [N];
    int pc [N];
    int pulses, stab, wcnt, hcnt, cyc, vcc_rise_t, vpp_fall_t, freads, vreads;
    int pw_err, su_err, hd_err, guard_err, sup_err, down_err, order_err, blind_rd_err, src_err;
    logic in_pulse, hwatch, p_ce, p_vcc, p_vpp, p_oe, p_req, p_valid;
    logic [7:0] pdata, p_dout;
    logic [AW-1:0] p_addr, p_saddr;

    assign mem_din = (!mem_ce_n && !mem_oe_n) ? devmem[mem_addr] : 8'h00;

    // Sample away from the active edge; update the model and tally timing faults.
    always @(negedge clk) begin
        if (mdl_clear) begin
            for (int a = 0; a < N; a++) begin devmem[a] = 8'hFF; pc[a] = 0; end
            pulses = 0; stab = 0; wcnt = 0; hcnt = 0; cyc = 0; vcc_rise_t = 0; vpp_fall_t = 0;
            freads = 0; vreads = 0; pw_err = 0; su_err = 0; hd_err = 0; guard_err = 0;
            sup_err = 0; down_err = 0; order_err = 0; blind_rd_err = 0; src_err = 0;
            in_pulse = 0; hwatch = 0; p_ce = 1; p_vcc = 0; p_vpp = 0; p_oe = 0;
            p_req = 0; p_valid = 0; pdata = 0; p_dout = 0; p_addr = 0; p_saddr = 0;
        end else begin
            if (vpp_en && !vcc_hi_en) sup_err++;
            if (vcc_hi_en && !p_vcc) vcc_rise_t = cyc;
            if (vpp_en && !p_vpp && (cyc - vcc_rise_t < TVCS)) sup_err++;
            if (!vpp_en && p_vpp) vpp_fall_t = cyc;
            if (!vcc_hi_en && p_vcc) begin
                if (p_vpp || (cyc - vpp_fall_t < TSU)) down_err++;
                if (corrupt_at >= 0) devmem[corrupt_at] = devmem[corrupt_at] ^ 8'h01;
            end
            if (mem_addr == p_addr && mem_dout == p_dout) stab++; else stab = 1;
            if (!mem_ce_n && p_ce && mem_dout_oe) begin
                pulses++;
                pc[mem_addr]++;
                if (pulses <= N && int'(mem_addr) != pulses - 1) order_err++;
                if (!vpp_en || !vcc_hi_en) sup_err++;
                if (stab < TSU + 1) su_err++;
                if (pc[mem_addr] >= need[mem_addr]) devmem[mem_addr] = devmem[mem_addr] & mem_dout;
                in_pulse = 1; wcnt = 0; pdata = mem_dout;
            end
            if (!mem_ce_n && in_pulse) wcnt++;
            if (mem_ce_n && !p_ce && in_pulse) begin
                in_pulse = 0;
                if (wcnt != TPW) pw_err++;
                hwatch = 1; hcnt = 0;
            end
            if (hwatch) begin
                if (mem_dout_oe && mem_dout == pdata) hcnt++;
                else begin if (hcnt < THD) hd_err++; hwatch = 0; end
            end
            if (!mem_ce_n && !mem_oe_n && p_ce) begin
                if (mem_dout_oe || p_oe) guard_err++;
                if (pulses < N) blind_rd_err++;
                if (vpp_en) vreads++;
                else if (!vcc_hi_en) freads++;
            end
            if (p_req && !p_valid && !src_req) src_err++;
            if (p_req && !p_valid && src_addr != p_saddr) src_err++;
            if (src_req && src_addr != mem_addr) src_err++;
            p_ce = mem_ce_n; p_vcc = vcc_hi_en; p_vpp = vpp_en; p_oe = mem_dout_oe;
            p_req = src_req; p_valid = src_valid; p_addr = mem_addr; p_dout = mem_dout;
            p_saddr = src_addr;
            cyc++;
        end
    end

    int n_checks = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected extra pulses in the verify pass for one address.
    function automatic int extra_of(input int a);
        if (pat[a] == 8'hFF || need[a] <= 1) return 0;
        return need[a] - 1;
    endfunction

    // Run one complete sequence and compare every observable with the model.
    task automatic run_scn(input string tag, input int corrupt, input bit poke);
        int exp_pc [N];
        int fail_at, cycles;
        bit exp_pass;
        fail_at = -1;
        for (int a = 0; a < N; a++) begin
            if (fail_at >= 0) exp_pc[a] = 1;
            else if (extra_of(a) > 10) begin exp_pc[a] = 11; fail_at = a; end
            else exp_pc[a] = 1 + extra_of(a);
        end
        corrupt_at = (fail_at < 0) ? corrupt : -1;
        if (fail_at < 0 && corrupt >= 0) fail_at = corrupt;
        exp_pass = (fail_at < 0);
        @(posedge clk); #1 mdl_clear = 1'b1;
        @(posedge clk); #1 mdl_clear = 1'b0; start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        @(negedge clk);
        chk(busy && !done, "R12", {tag, " start clears done, sets busy"}, {busy, done}, 2);
        cycles = 0;
        while (!done && cycles < RUN_LIMIT) begin
            if (poke && cycles == 500) begin
                @(posedge clk); #1 start = 1'b1;
                @(posedge clk); #1 start = 1'b0;
            end
            @(negedge clk);
            cycles++;
        end
        chk(done, "R11", {tag, " run completes"}, cycles, RUN_LIMIT);
        chk(pass == exp_pass && fail == !exp_pass, "R11", {tag, " verdict"}, {pass, fail}, {exp_pass, !exp_pass});
        if (!exp_pass) chk(int'(fail_addr) == fail_at, "R8", {tag, " failing address"}, fail_addr, fail_at);
        for (int a = 0; a < N; a++)
            chk(pc[a] == exp_pc[a], "R7", $sformatf("%s pulses at address %0d (R6 R8)", tag, a), pc[a], exp_pc[a]);
        chk(pw_err == 0, "R4", {tag, " pulse width"}, pw_err, 0);
        chk(su_err == 0 && hd_err == 0, "R5", {tag, " setup/hold"}, su_err + hd_err, 0);
        chk(order_err == 0 && blind_rd_err == 0, "R6", {tag, " blind order, no early reads"}, order_err + blind_rd_err, 0);
        chk(guard_err == 0, "R9", {tag, " read bus guard"}, guard_err, 0);
        chk(sup_err == 0, "R3", {tag, " supply power-up order"}, sup_err, 0);
        chk(down_err == 0 && !vpp_en && !vcc_hi_en, "R10", {tag, " supply power-down order"}, down_err, 0);
        chk(src_err == 0, "R13", {tag, " byte request handshake"}, src_err, 0);
        chk(freads == (exp_pass ? N : (corrupt_at >= 0 ? corrupt_at + 1 : 0)), "R11",
            {tag, " unpowered read-back count"}, freads, exp_pass ? N : (corrupt_at >= 0 ? corrupt_at + 1 : 0));
        chk(!busy && mem_ce_n && mem_oe_n && !mem_dout_oe, "R2", {tag, " idle after run"}, busy, 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int a = 0; a < N; a++) begin pat[a] = 8'h00; need[a] = 1; end
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(!busy && !done && !pass && !fail, "R1", "reset status", {busy, done, pass, fail}, 0);
        chk(!vcc_hi_en && !vpp_en && mem_ce_n && mem_oe_n && !mem_dout_oe && !src_req, "R1",
            "reset bus and supplies", {vcc_hi_en, vpp_en, mem_ce_n, mem_oe_n}, 4'b0011);
        @(posedge clk); #1 rst_n = 1'b1;

        // All bytes take on the first pulse.
        for (int a = 0; a < N; a++) begin pat[a] = 8'($urandom % 255); need[a] = 1; end
        run_scn("first-pulse", -1, 1'b0);
        repeat (40) @(negedge clk);
        chk(done && pass && !fail, "R12", "result holds while idle", {done, pass, fail}, 3'b110);

        // Random pulse needs; an erased-value byte matches without programming.
        for (int a = 0; a < N; a++) begin pat[a] = 8'($urandom % 255); need[a] = 1 + int'($urandom % 9); end
        pat[2] = 8'hFF; need[2] = 20;
        run_scn("random-need", -1, 1'b0);

        // Exactly ten extra pulses at the last address passes; a start mid-run is ignored.
        for (int a = 0; a < N; a++) begin pat[a] = 8'($urandom % 255); need[a] = 1 + int'($urandom % 4); end
        need[N-1] = 11;
        run_scn("limit-pass", -1, 1'b1);

        // Eleven needed extra pulses: fail at address 4.
        for (int a = 0; a < N; a++) begin pat[a] = 8'($urandom % 255); need[a] = 1 + int'($urandom % 3); end
        pat[4] = 8'h3C; need[4] = 12;
        run_scn("limit-fail", -1, 1'b0);

        // A cell flips after power-down: unpowered read-back fails at address 6.
        for (int a = 0; a < N; a++) begin pat[a] = 8'($urandom % 255); need[a] = 1 + int'($urandom % 5); end
        run_scn("readback-fail", 6, 1'b0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        #(CLK_PERIOD * 190000);
        n_checks++;
        n_fail++;
        $display("FAIL R11 watchdog expired actual=%0d expected=%0d", 190000, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule